// File: doc/BRIEF.md
# USB Suspend and Wakeup Detector

This block watches traffic on a full-speed USB device port. While checking is enabled and the bus stays silent for a configurable number of clock cycles, it raises a one-cycle suspend request. The default length is 3 ms worth of cycles. The check starts only after a USB reset has been seen. Software then sets a force-suspend control bit. While that bit is set, and until the resume sequence is reported complete, the idle check stays off.

While the port is suspended, any bus activity counts as a wakeup. The block gives a one-cycle wakeup pulse. It raises a wakeup line that tells other units to begin resuming, and it holds that line until the end of resume. A separate path clears the low-power-mode control bit at once. This path uses the raw activity input and needs no clock edge, because the clock may be stopped. The timer and the wakeup pulse use a two-flop synchronized copy of the activity input.

Top module: `usb_suspend_wake`

## Requirements
- R1: After `rst_n` is released, all outputs are 0. No suspend request is ever raised until a USB reset pulse has been sampled.
- R2: Edge 1 is the clock edge that samples `usb_rst_evt` high. If the bus is then silent, `susp_req` is first high after edge IDLE_CYC+1.
- R3: Edge 1 is the edge that first samples an activity strobe. The strobe restarts the idle count, and `susp_req` is first high after edge IDLE_CYC+3. Two of these edges are synchronizer delay.
- R4: `susp_req` is high for exactly one cycle. It fires again only after new activity and a further full idle period.
- R5: While `force_susp` is 1, no suspend request is raised. Checking stays off after `force_susp` returns to 0 and until `resume_done` is sampled. Edge 1 is the edge that samples `resume_done`. A fresh count then starts, and `susp_req` is first high after edge IDLE_CYC+1.
- R6: Edge 1 is the edge that samples activity during suspend mode. `wake_pulse` is high for one cycle after edge 3, and `wake_line` rises with it. Activity outside suspend mode produces no wakeup.
- R7: `wake_line` stays 1 until the edge that samples `resume_done`, and it is 0 after that edge. More activity while `wake_line` is 1 produces no further `wake_pulse`.
- R8: `lp_clear` is 1 combinationally whenever `bus_act` is 1 in suspend mode, with no clock edge needed. It is 0 when not in suspend mode.
- R9: Suppose `force_susp` and `resume_done` are sampled high in the same cycle. The force wins, and checking stays off until a later `resume_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_act | input | 1 | Asynchronous bus-activity strobe from the line-state decoder |
| usb_rst_evt | input | 1 | One-cycle pulse: a USB bus reset was detected |
| force_susp | input | 1 | Force-suspend control bit from software |
| resume_done | input | 1 | One-cycle pulse: the resume sequence has finished |
| susp_req | output | 1 | One-cycle suspend request after the idle period |
| wake_pulse | output | 1 | One-cycle wakeup event |
| wake_line | output | 1 | Wakeup indication to the rest of the chip, held until resume ends |
| lp_clear | output | 1 | Unclocked clear for the low-power-mode control bit |

## Verification
The bench measures the exact cycle in which the suspend request first appears after three events: a USB reset, an activity strobe, and the end of resume. An off-by-one in the counter, or a missing synchronizer stage, moves that cycle and is reported. It holds the bus silent for several idle periods to catch two faults: a request that repeats, and one raised before any USB reset. It also drops force-suspend without ending resume, and pulses both controls in the same cycle. A design that re-enabled checking too early would then produce a request. Wakeup tests check that `lp_clear` follows the raw input before any clock edge. They also check that a second burst of activity does not re-pulse, and that activity outside suspend leaves every wakeup output low.

// File: rtl/usw_pkg.sv
// Package: shared types and default timing for the suspend/wakeup detector.
// Assumes: the default idle length is 3 ms at a 48 MHz clock.
package usw_pkg;
    localparam int unsigned DEF_IDLE_CYC = 144000;

    typedef enum logic [1:0] {
        MON_OFF   = 2'd0,   // no USB reset seen yet
        MON_WATCH = 2'd1,   // idle check running
        MON_SUSP  = 2'd2    // suspend forced or resume pending
    } mon_mode_e;
endpackage

// File: rtl/usw_sync.sv
// Module: multi-flop synchronizer for the asynchronous activity strobe.
// Assumes: the strobe is held long enough to be seen at the clock rate.
module usw_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/usw_arm.sv
// Module: enable/disable sequencing for the idle check.
// Arms on a USB reset. A force-suspend sets a lock that only resume_done
// releases. If both arrive in the same cycle, the force wins.
// Assumes: usb_rst_evt and resume_done are synchronous one-cycle pulses.
module usw_arm
    import usw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      usb_rst_evt,
    input  logic      force_susp,
    input  logic      resume_done,
    output mon_mode_e mode
);
    logic armed;
    logic lock;

    // Arming is sticky once a USB reset has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n)           armed <= 1'b0;
        else if (usb_rst_evt) armed <= 1'b1;
    end

    // The suspend lock is set by force and cleared by end of resume.
    always_ff @(posedge clk) begin
        if (!rst_n)           lock <= 1'b0;
        else if (force_susp)  lock <= 1'b1;
        else if (resume_done) lock <= 1'b0;
    end

    // Select the current mode; suspend outranks watching.
    always_comb begin
        if (force_susp || lock) mode = MON_SUSP;
        else if (armed)         mode = MON_WATCH;
        else                    mode = MON_OFF;
    end

    p_unarmed_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (mode != MON_WATCH));
    p_lock_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        force_susp |=> (mode == MON_SUSP));
endmodule

// File: rtl/usw_idle_timer.sv
// Module: idle counter that raises a one-cycle suspend request.
// Any synchronized activity, or a disabled check, clears the count.
// After firing, the counter waits for new activity before it counts again.
// Assumes: IDLE_CYC >= 2.
module usw_idle_timer #(
    parameter int unsigned IDLE_CYC = usw_pkg::DEF_IDLE_CYC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chk_active,
    input  logic act_seen,
    output logic susp_req
);
    localparam int unsigned CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC - 1);

    logic [CW-1:0] cnt;
    logic          fired;
    logic          hit;

    assign hit = chk_active && !act_seen && !fired && (cnt == LIMIT);

    // Count idle cycles, fire once, and rearm on activity or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            fired    <= 1'b0;
            susp_req <= 1'b0;
        end else begin
            susp_req <= hit;
            if (!chk_active || act_seen) begin
                cnt   <= '0;
                fired <= 1'b0;
            end else if (hit) begin
                fired <= 1'b1;
            end else if (!fired) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        susp_req |=> !susp_req);
    p_req_needs_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
        susp_req |-> $past(chk_active));
endmodule

// File: rtl/usw_wake.sv
// Module: wakeup handling. Activity during suspend gives one pulse and a
// line that is held until end of resume. The low-power clear uses the raw
// input, so it works with no clock running.
// Assumes: resume_done is a synchronous one-cycle pulse.
module usw_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic act_raw,
    input  logic act_seen,
    input  logic susp_mode,
    input  logic resume_done,
    output logic wake_pulse,
    output logic wake_line,
    output logic lp_clear
);
    logic wake_set;

    assign wake_set = act_seen && susp_mode && !wake_line;

    // Produce the pulse and hold the line until resume completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_pulse <= 1'b0;
            wake_line  <= 1'b0;
        end else begin
            wake_pulse <= wake_set;
            if (resume_done)   wake_line <= 1'b0;
            else if (wake_set) wake_line <= 1'b1;
        end
    end

    // Unclocked clear of the low-power bit from the raw detection.
    assign lp_clear = act_raw && susp_mode;

    p_wake_needs_susp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(susp_mode));
    p_wake_line_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> wake_line);
    p_wake_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_line && !resume_done) |=> wake_line);
    p_wake_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
endmodule

// File: rtl/usb_suspend_wake.sv
// Module: top of the USB suspend/wakeup detector. It ties together the
// synchronizer, the arming sequencer, the idle timer and the wakeup logic.
// Assumes: bus_act is asynchronous; all other inputs are synchronous to clk.
module usb_suspend_wake
    import usw_pkg::*;
#(
    parameter int unsigned IDLE_CYC    = DEF_IDLE_CYC,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_act,
    input  logic usb_rst_evt,
    input  logic force_susp,
    input  logic resume_done,
    output logic susp_req,
    output logic wake_pulse,
    output logic wake_line,
    output logic lp_clear
);
    logic      act_seen;
    mon_mode_e mode;

    usw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(bus_act), .q_sync(act_seen)
    );

    usw_arm u_arm (
        .clk(clk), .rst_n(rst_n), .usb_rst_evt(usb_rst_evt),
        .force_susp(force_susp), .resume_done(resume_done), .mode(mode)
    );

    usw_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .chk_active(mode == MON_WATCH),
        .act_seen(act_seen), .susp_req(susp_req)
    );

    usw_wake u_wake (
        .clk(clk), .rst_n(rst_n), .act_raw(bus_act), .act_seen(act_seen),
        .susp_mode(mode == MON_SUSP), .resume_done(resume_done),
        .wake_pulse(wake_pulse), .wake_line(wake_line), .lp_clear(lp_clear)
    );

    p_no_req_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_susp |=> !susp_req);
endmodule

// File: tb/usb_suspend_wake_bench.sv
module usb_suspend_wake_bench;
    localparam int IDLE = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_act = 1'b0;
    logic usb_rst_evt = 1'b0;
    logic force_susp = 1'b0;
    logic resume_done = 1'b0;
    logic susp_req, wake_pulse, wake_line, lp_clear;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    usb_suspend_wake #(.IDLE_CYC(IDLE)) u_usb_suspend_wake (
        .clk(clk), .rst_n(rst_n), .bus_act(bus_act), .usb_rst_evt(usb_rst_evt),
        .force_susp(force_susp), .resume_done(resume_done),
        .susp_req(susp_req), .wake_pulse(wake_pulse),
        .wake_line(wake_line), .lp_clear(lp_clear)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_act = 1'b0; usb_rst_evt = 1'b0;
        force_susp = 1'b0; resume_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Called right after an input was driven at a negedge. Samples after
    // edges 1..n and drops all pulse inputs after edge 1.
    task automatic watch_req(input int n, output int first, output int cnt);
        first = 0; cnt = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (i == 1) begin
                usb_rst_evt = 1'b0; bus_act = 1'b0; resume_done = 1'b0;
            end
            if (susp_req) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
    endtask

    task automatic t_reset_state();
        int f, c;
        do_reset();
        chk(!susp_req && !wake_pulse && !wake_line && !lp_clear, "R1 outputs after reset",
            {susp_req, wake_pulse, wake_line, lp_clear}, 0);
        watch_req(3 * IDLE, f, c);
        chk(c == 0, "R1 no request without USB reset", c, 0);
    endtask

    task automatic t_idle_after_reset();
        int f, c;
        do_reset();
        @(negedge clk); usb_rst_evt = 1'b1;
        watch_req(4 * IDLE, f, c);
        chk(f == IDLE + 1, "R2 first request edge", f, IDLE + 1);
        chk(c == 1, "R4 single non-repeating pulse", c, 1);
    endtask

    task automatic t_activity_restart();
        int f, c;
        do_reset();
        @(negedge clk); usb_rst_evt = 1'b1;
        watch_req(20, f, c);
        chk(c == 0, "R3 no request mid-period", c, 0);
        bus_act = 1'b1;
        watch_req(IDLE + 10, f, c);
        chk(f == IDLE + 3, "R3 restart timing", f, IDLE + 3);
        bus_act = 1'b1;
        watch_req(IDLE + 10, f, c);
        chk(f == IDLE + 3 && c == 1, "R4 re-fires after new activity", f, IDLE + 3);
    endtask

    task automatic t_force_suspend();
        int f, c;
        do_reset();
        @(negedge clk); usb_rst_evt = 1'b1;
        @(negedge clk); usb_rst_evt = 1'b0; force_susp = 1'b1;
        watch_req(3 * IDLE, f, c);
        chk(c == 0, "R5 no request while forced", c, 0);
        force_susp = 1'b0;
        watch_req(3 * IDLE, f, c);
        chk(c == 0, "R5 still off before resume_done", c, 0);
        resume_done = 1'b1;
        watch_req(2 * IDLE, f, c);
        chk(f == IDLE + 1, "R5 fresh count after resume_done", f, IDLE + 1);
    endtask

    task automatic t_wakeup();
        int first;
        int pulses;
        do_reset();
        @(negedge clk); usb_rst_evt = 1'b1;
        @(negedge clk); usb_rst_evt = 1'b0;
        bus_act = 1'b1;
        #1;
        chk(lp_clear == 1'b0, "R8 no clear outside suspend", lp_clear, 0);
        pulses = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (i == 1) bus_act = 1'b0;
            if (wake_pulse || wake_line) pulses++;
        end
        chk(pulses == 0, "R6 no wake outside suspend", pulses, 0);
        force_susp = 1'b1;
        @(negedge clk);
        bus_act = 1'b1;
        #1;
        chk(lp_clear == 1'b1, "R8 unclocked clear in suspend", lp_clear, 1);
        first = 0; pulses = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (i == 1) bus_act = 1'b0;
            if (wake_pulse) begin
                pulses++;
                if (first == 0) first = i;
            end
        end
        chk(first == 3, "R6 wake pulse edge", first, 3);
        chk(wake_line == 1'b1, "R6 wake line raised", wake_line, 1);
        bus_act = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (i == 1) bus_act = 1'b0;
            if (wake_pulse) pulses++;
        end
        chk(pulses == 1, "R7 no second wake pulse", pulses, 1);
        chk(wake_line == 1'b1, "R7 line held before resume", wake_line, 1);
        force_susp = 1'b0;
        resume_done = 1'b1;
        @(negedge clk); resume_done = 1'b0;
        chk(wake_line == 1'b0, "R7 line cleared by resume_done", wake_line, 0);
    endtask

    task automatic t_tie();
        int f, c;
        do_reset();
        @(negedge clk); usb_rst_evt = 1'b1;
        @(negedge clk); usb_rst_evt = 1'b0; force_susp = 1'b1;
        @(negedge clk); resume_done = 1'b1;
        @(negedge clk); resume_done = 1'b0; force_susp = 1'b0;
        watch_req(3 * IDLE, f, c);
        chk(c == 0, "R9 force wins over resume_done", c, 0);
        resume_done = 1'b1;
        watch_req(2 * IDLE, f, c);
        chk(f == IDLE + 1, "R9 later resume_done re-enables", f, IDLE + 1);
    endtask

    initial begin
        t_reset_state();
        t_idle_after_reset();
        t_activity_restart();
        t_force_suspend();
        t_wakeup();
        t_tie();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule